// File: doc/BRIEF.md
# Wide Flash Line Burst Reader

This block connects the wide read port of a flash array to a 64-bit instruction fetch bus. A requester hands it a line address through a valid/ready handshake. The block then issues a one-cycle read strobe to the array and waits for the array to return a 256-bit line together with 32 check bits. It stores the line and sends it out as a fixed burst of four 64-bit beats.

Each beat passes through a single-error-correcting, double-error-detecting decoder as it leaves the block. Every beat is tagged with its own corrected flag and its own uncorrectable flag. The code is an extended Hamming code over each 64-bit word. An erased word, which reads as all zeros, is therefore a valid codeword and raises no flag.

The block takes one request at a time. It takes no new address until the fourth beat of the current burst has left.

Top module: `flb_burst_reader`

## Requirements
- R1: `req_ready` is high only while the block is idle, meaning no read is outstanding and no burst is in progress. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. In the next cycle `arr_rd` is high for exactly one cycle, and `arr_addr` equals the address that was taken.
- R2: The block captures the returned line on the first edge after the read strobe where `arr_rvalid` is high. The first beat is presented in the following cycle. `arr_rvalid` has no effect while the block is idle: no beat follows it.
- R3: A burst is exactly four beats long. The beats occupy four consecutive cycles with `beat_valid` high in each, and there is no idle cycle between them.
- R4: Beat k (k = 0..3) carries line bits [64k+63:64k] and is checked with `arr_chk` bits [8k+7:8k], so beats go from the lowest word to the highest. `beat_last` is high on beat 3 only.
- R5: Check-bit layout of each beat. The 64 data bits take codeword positions 3, 5, 6, 7, 9, … in ascending order; a position is skipped when it is a power of two. Check bit i (i = 0..6) is the XOR of the data bits whose position has bit i set. Check bit 7 is the XOR of all data bits and check bits 0..6. An all-zero word with all-zero check bits gives a zero beat and no flags.
- R6: When exactly one of the 72 codeword bits of a beat is flipped, the beat carries the original data, `beat_corr` is 1 and `beat_uncorr` is 0. This holds whether the flipped bit is a data bit or a check bit.
- R7: When exactly two of the 72 bits of a beat are flipped, `beat_uncorr` is 1 and `beat_corr` is 0. The beat carries the received data bits unchanged.
- R8: `beat_corr` and `beat_uncorr` are 0 in every cycle where `beat_valid` is 0. The two flags are never high together.
- R9: In the cycle after the last beat, `beat_valid` is 0 and `req_ready` is 1. A `req_valid` held high during a burst does not produce a read strobe during that burst.
- R10: A beat with no flipped bit carries its data unchanged, and both of its flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Line request valid |
| req_addr | input | ADDR_W | Line address of the request |
| req_ready | output | 1 | Block is idle and can take a request |
| arr_rd | output | 1 | One-cycle read strobe to the array |
| arr_addr | output | ADDR_W | Line address presented to the array |
| arr_rvalid | input | 1 | Array line data is valid |
| arr_data | input | 256 | Raw line data from the array |
| arr_chk | input | 32 | Raw check bits, 8 per 64-bit word |
| beat_valid | output | 1 | Beat strobe |
| beat_data | output | 64 | Beat data after correction |
| beat_last | output | 1 | High on the fourth beat of a burst |
| beat_corr | output | 1 | Single error corrected in this beat |
| beat_uncorr | output | 1 | Uncorrectable error detected in this beat |

## Verification
The assertions assume that the array answers each read strobe with exactly one `arr_rvalid` pulse. The bench models the array as a task that drives that single pulse after a random delay of zero to three cycles. The ECC assertions assume that a raw beat holds at most two flipped bits; with three or more flips the code can mistake the error for a single one. The stimulus therefore draws zero, one or two distinct flip positions per beat. The bench also drives `arr_rvalid` once while the block is idle, and it holds `req_valid` high through one burst.

// File: rtl/flb_pkg.sv
package flb_pkg;
  parameter int BEAT_W = 64;
  parameter int BEATS  = 4;
  localparam int HAM_W  = $clog2(BEAT_W) + 1;
  localparam int CHK_W  = HAM_W + 1;
  localparam int LINE_W = BEAT_W * BEATS;
  localparam int LCHK_W = CHK_W * BEATS;
  localparam int NPOS   = 2 ** HAM_W;

  typedef logic [BEAT_W-1:0] beat_t;
  typedef logic [CHK_W-1:0]  chk_t;
  typedef logic [HAM_W-1:0]  syn_t;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_BURST} st_e;

  // XOR of the codeword positions of all set data bits (powers of two skipped)
  function automatic syn_t ham_fold(input beat_t d);
    syn_t acc = '0;
    int   k   = 0;
    for (int p = 1; p < NPOS; p++) begin
      if (((p & (p - 1)) != 0) && (k < BEAT_W)) begin
        if (d[k]) acc ^= syn_t'(p);
        k++;
      end
    end
    return acc;
  endfunction

  // full check byte: Hamming bits plus overall parity on top
  function automatic chk_t ecc_encode(input beat_t d);
    syn_t h;
    h = ham_fold(d);
    return {(^d) ^ (^h), h};
  endfunction

  // data-bit mask selected by a syndrome; zero if it names no data bit
  function automatic beat_t flip_mask(input syn_t s);
    beat_t m = '0;
    int    k = 0;
    for (int p = 1; p < NPOS; p++) begin
      if (((p & (p - 1)) != 0) && (k < BEAT_W)) begin
        if (syn_t'(p) == s) m[k] = 1'b1;
        k++;
      end
    end
    return m;
  endfunction
endpackage

// File: rtl/flb_secded_dec.sv
module flb_secded_dec
  import flb_pkg::*;
(
  input  beat_t din,
  input  chk_t  cin,
  output beat_t dout,
  output logic  corr,
  output logic  uncorr
);
  syn_t  syn;
  logic  par_odd;
  beat_t mask;
  logic  hit_data;
  logic  hit_chk;

  assign syn      = ham_fold(din) ^ cin[HAM_W-1:0];
  assign par_odd  = (^din) ^ (^cin);
  assign mask     = flip_mask(syn);
  assign hit_data = |mask;
  assign hit_chk  = par_odd && ((syn == '0) || $onehot(syn));

  assign corr   = par_odd && (hit_data || hit_chk);
  assign uncorr = (!par_odd && (syn != '0)) || (par_odd && !hit_data && !hit_chk);
  assign dout   = par_odd ? (din ^ mask) : din;

  // a word the decoder does not call corrected leaves untouched (R10, R7)
  always_comb begin
    if (!corr) p_passthru_r10: assert (dout == din);
  end
endmodule

// File: rtl/flb_line_buf.sv
module flb_line_buf
  import flb_pkg::*;
#(
  parameter int NBEATS = BEATS,
  localparam int IDX_W = (NBEATS > 1) ? $clog2(NBEATS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cap,
  input  logic [BEAT_W*NBEATS-1:0]  line_in,
  input  logic [CHK_W*NBEATS-1:0]   chk_in,
  input  logic [IDX_W-1:0]          idx,
  output beat_t                     beat_o,
  output chk_t                      chk_o
);
  logic [BEAT_W*NBEATS-1:0] line_q;
  logic [CHK_W*NBEATS-1:0]  chk_q;
  beat_t                    words [NBEATS];
  chk_t                     bytes [NBEATS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      chk_q  <= '0;
    end else if (cap) begin
      line_q <= line_in;
      chk_q  <= chk_in;
    end
  end

  for (genvar g = 0; g < NBEATS; g++) begin : g_split
    assign words[g] = line_q[g*BEAT_W +: BEAT_W];
    assign bytes[g] = chk_q[g*CHK_W +: CHK_W];
  end

  assign beat_o = words[idx];
  assign chk_o  = bytes[idx];
endmodule

// File: rtl/flb_ctrl.sv
module flb_ctrl
  import flb_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int NBEATS = BEATS,
  localparam int IDX_W = (NBEATS > 1) ? $clog2(NBEATS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              arr_rd,
  output logic [ADDR_W-1:0] arr_addr,
  input  logic              arr_rvalid,
  output logic              cap,
  output logic              beat_valid,
  output logic [IDX_W-1:0]  beat_idx,
  output logic              beat_last
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBEATS - 1);

  st_e               st_q, st_d;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] addr_q;
  logic              accept;
  logic              burst_done;

  assign accept     = req_valid && (st_q == ST_IDLE);
  assign cap        = arr_rvalid && (st_q == ST_WAIT);
  assign burst_done = (st_q == ST_BURST) && (idx_q == LAST_IDX);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (accept)     st_d = ST_ISSUE;
      ST_ISSUE:                 st_d = ST_WAIT;
      ST_WAIT:  if (cap)        st_d = ST_BURST;
      ST_BURST: if (burst_done) st_d = ST_IDLE;
      default:                  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      addr_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept) addr_q <= req_addr;
      if (cap) idx_q <= '0;
      else if (st_q == ST_BURST) idx_q <= idx_q + 1'b1;
    end
  end

  assign req_ready  = (st_q == ST_IDLE);
  assign arr_rd     = (st_q == ST_ISSUE);
  assign arr_addr   = addr_q;
  assign beat_valid = (st_q == ST_BURST);
  assign beat_idx   = idx_q;
  assign beat_last  = beat_valid && (idx_q == LAST_IDX);

  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!beat_valid && !arr_rd));
  p_rd_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (arr_rd && (arr_addr == $past(req_addr))));
  p_first_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> (beat_valid && (beat_idx == '0)));
  p_burst_gapless_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_last) |=> beat_valid);
  p_beat_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_last) |=> (beat_idx == IDX_W'($past(beat_idx) + 1'b1)));
  p_ready_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |=> (req_ready && !beat_valid));
endmodule

// File: rtl/flb_burst_reader.sv
module flb_burst_reader
  import flb_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [ADDR_W-1:0]   req_addr,
  output logic                req_ready,
  output logic                arr_rd,
  output logic [ADDR_W-1:0]   arr_addr,
  input  logic                arr_rvalid,
  input  logic [LINE_W-1:0]   arr_data,
  input  logic [LCHK_W-1:0]   arr_chk,
  output logic                beat_valid,
  output logic [BEAT_W-1:0]   beat_data,
  output logic                beat_last,
  output logic                beat_corr,
  output logic                beat_uncorr
);
  localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic             cap;
  logic [IDX_W-1:0] beat_idx;
  beat_t            raw_beat;
  chk_t             raw_chk;
  logic             dec_corr;
  logic             dec_uncorr;

  flb_ctrl #(.ADDR_W(ADDR_W), .NBEATS(BEATS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_ready  (req_ready),
    .arr_rd     (arr_rd),
    .arr_addr   (arr_addr),
    .arr_rvalid (arr_rvalid),
    .cap        (cap),
    .beat_valid (beat_valid),
    .beat_idx   (beat_idx),
    .beat_last  (beat_last)
  );

  flb_line_buf #(.NBEATS(BEATS)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap     (cap),
    .line_in (arr_data),
    .chk_in  (arr_chk),
    .idx     (beat_idx),
    .beat_o  (raw_beat),
    .chk_o   (raw_chk)
  );

  flb_secded_dec u_dec (
    .din    (raw_beat),
    .cin    (raw_chk),
    .dout   (beat_data),
    .corr   (dec_corr),
    .uncorr (dec_uncorr)
  );

  assign beat_corr   = beat_valid && dec_corr;
  assign beat_uncorr = beat_valid && dec_uncorr;

  p_flags_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_valid |-> (!beat_corr && !beat_uncorr));
  p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(beat_corr && beat_uncorr));
endmodule

// File: tb/flb_burst_reader_tb.sv
module flb_burst_reader_tb;
  import flb_pkg::*;
  localparam int AW = 20;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [AW-1:0]     req_addr = '0;
  logic              req_ready;
  logic              arr_rd;
  logic [AW-1:0]     arr_addr;
  logic              arr_rvalid = 1'b0;
  logic [LINE_W-1:0] arr_data = '0;
  logic [LCHK_W-1:0] arr_chk = '0;
  logic              beat_valid;
  logic [BEAT_W-1:0] beat_data;
  logic              beat_last;
  logic              beat_corr;
  logic              beat_uncorr;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  flb_burst_reader #(.ADDR_W(AW)) u_dut (.*);

  // bench-side code layout: codeword position of each data bit
  int pos_of [BEAT_W];
  initial begin
    int p = 1;
    for (int k = 0; k < BEAT_W; k++) begin
      p++;
      while ((p & (p - 1)) == 0) p++;
      pos_of[k] = p;
    end
  end

  function automatic logic [7:0] tb_enc(input logic [63:0] d);
    logic [7:0] c = '0;
    for (int i = 0; i < 7; i++)
      for (int k = 0; k < 64; k++)
        if (d[k] && pos_of[k][i]) c[i] = ~c[i];
    c[7] = ^{d, c[6:0]};
    return c;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // stimulus for one line
  logic [255:0] t_line;
  int           t_n  [4];
  int           t_fa [4];
  int           t_fb [4];

  task automatic run_line(input logic [AW-1:0] a, input int lat, input bit hold);
    logic [71:0]  cw [4];
    logic [63:0]  exp_d [4];
    logic         exp_c [4];
    logic         exp_u [4];
    for (int b = 0; b < 4; b++) begin
      logic [63:0] d;
      d = t_line[64*b +: 64];
      cw[b] = {tb_enc(d), d};
      if (t_n[b] >= 1) cw[b][t_fa[b]] = ~cw[b][t_fa[b]];
      if (t_n[b] >= 2) cw[b][t_fb[b]] = ~cw[b][t_fb[b]];
      exp_d[b] = (t_n[b] == 2) ? cw[b][63:0] : d;
      exp_c[b] = (t_n[b] == 1);
      exp_u[b] = (t_n[b] == 2);
      arr_data[64*b +: 64] = cw[b][63:0];
      arr_chk[8*b +: 8]    = cw[b][71:64];
    end
    check("R1 ready before request", 64'(req_ready), 64'd1);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 read strobe", 64'(arr_rd), 64'd1);
    check("R1 array address", 64'(arr_addr), 64'(a));
    check("R1 ready low while busy", 64'(req_ready), 64'd0);
    @(negedge clk);
    check("R1 strobe lasts one cycle", 64'(arr_rd), 64'd0);
    for (int i = 0; i < lat; i++) @(negedge clk);
    arr_rvalid = 1'b1;
    @(negedge clk);
    arr_rvalid = 1'b0;
    if (hold) begin
      req_valid = 1'b1;
      req_addr  = ~a;
    end
    for (int b = 0; b < 4; b++) begin
      check("R3 beat valid", 64'(beat_valid), 64'd1);
      check("R4 beat data order", beat_data, exp_d[b]);
      check("R4 last marker", 64'(beat_last), 64'(b == 3));
      check((t_n[b] == 1) ? "R6 corrected flag" : "R10 corrected flag", 64'(beat_corr), 64'(exp_c[b]));
      check((t_n[b] == 2) ? "R7 uncorrectable flag" : "R10 uncorrectable flag", 64'(beat_uncorr), 64'(exp_u[b]));
      if (hold) begin
        check("R9 no strobe during burst", 64'(arr_rd), 64'd0);
        check("R9 ready low during burst", 64'(req_ready), 64'd0);
      end
      if (b == 3) req_valid = 1'b0;
      @(negedge clk);
    end
    check("R9 burst ended", 64'(beat_valid), 64'd0);
    check("R9 ready after last", 64'(req_ready), 64'd1);
    check("R8 flags idle", 64'({beat_corr, beat_uncorr}), 64'd0);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset ready", 64'(req_ready), 64'd1);
    check("R1 reset no strobe", 64'(arr_rd), 64'd0);
    check("R8 reset no beat", 64'({beat_valid, beat_corr, beat_uncorr}), 64'd0);

    // R2: rvalid while idle produces no beat
    arr_rvalid = 1'b1;
    arr_data   = {4{64'hDEAD_BEEF_0123_4567}};
    @(negedge clk);
    arr_rvalid = 1'b0;
    check("R2 idle rvalid ignored", 64'(beat_valid), 64'd0);
    @(negedge clk);
    check("R2 idle rvalid ignored later", 64'(beat_valid), 64'd0);

    // R5: erased line
    t_line = '0;
    for (int b = 0; b < 4; b++) t_n[b] = 0;
    run_line(20'h00010, 0, 1'b0);

    // directed flips: data bit, Hamming check bit, overall parity, double
    t_line = {64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001, 64'hA5A5_5A5A_C3C3_3C3C};
    t_n[0] = 1; t_fa[0] = 0;
    t_n[1] = 1; t_fa[1] = 67;
    t_n[2] = 1; t_fa[2] = 71;
    t_n[3] = 2; t_fa[3] = 63; t_fb[3] = 70;
    run_line(20'hABCDE, 2, 1'b1);

    // double flip on the top data bits and a single on bit 63
    t_n[0] = 2; t_fa[0] = 62; t_fb[0] = 63;
    t_n[1] = 1; t_fa[1] = 63;
    t_n[2] = 0;
    t_n[3] = 2; t_fa[3] = 64; t_fb[3] = 71;
    run_line(20'hFFFFF, 1, 1'b0);

    // constrained random lines
    for (int l = 0; l < 60; l++) begin
      for (int w = 0; w < 8; w++) t_line[32*w +: 32] = $urandom;
      for (int b = 0; b < 4; b++) begin
        t_n[b]  = $urandom_range(0, 2);
        t_fa[b] = $urandom_range(0, 71);
        t_fb[b] = $urandom_range(0, 70);
        if (t_fb[b] >= t_fa[b]) t_fb[b]++;
      end
      run_line(AW'($urandom), $urandom_range(0, 3), (l % 7) == 3);
    end
    summary();
  end
endmodule